// File: doc/BRIEF.md
# Processor Mode Control Register

This block holds the eight mode bits that steer a processor core: which arithmetic register bank is active, bit-reversed addressing, overflow latching, saturation, multiplier result placement, the timer, the address register bank, and the global interrupt gate. Each bit is driven out as its own registered signal, so the rest of the core reads its modes directly.

The register can be changed in two ways. A mode-control operation carries an enable mask and a disable mask. A legal operation takes effect on the very next clock. An operation that holds set bits in both masks is refused: the register keeps its value and a one-cycle error pulse is raised. A direct write passes through a fixed pipeline latency before it lands. Any legal operation issued while that write is in flight is applied at once to the live register. When the write lands, the same operation is applied again on top of the written value, so it is not lost. The read port always shows the value that is in effect now, never a write that has not landed yet.

Top module: `mode_reg_ctl`

## Requirements
- R1: After a synchronous reset, rd_data is 0x00, every mode output is low and op_illegal is low.
- R2: A legal operation with op_valid high sets the bits of op_set, and the new value is on rd_data in the cycle after the clock edge that sampled it.
- R3: A legal operation clears the bits of op_clr, and the new value is visible in the cycle after the sampling edge.
- R4: One operation may set several bits at once or clear several bits at once; all named bits change on the same edge.
- R5: An operation with op_valid high and both op_set and op_clr non-zero leaves rd_data unchanged and drives op_illegal high for exactly the one following cycle. op_illegal is low at every other time.
- R6: A direct write sampled with wr_en high appears on rd_data exactly LAT edges later (LAT = 2 by default). Until then rd_data keeps the value in effect.
- R7: A legal operation sampled while a write is in flight, including on the edge where the write lands, is applied to the live value at once and applied again, in issue order, on top of the written data when the write lands.
- R8: Writes on consecutive cycles each land in turn, one edge apart, in the order they were issued.
- R9: Bit mapping of rd_data: bit 0 arith_bank_sel, bit 1 bitrev_en, bit 2 ovf_latch_en, bit 3 sat_en, bit 4 mul_place_en, bit 5 timer_en, bit 6 alt_bank_sel (1 = secondary address register bank), bit 7 gie (global interrupt enable).
- R10: While op_valid is low, op_set and op_clr have no effect.
- R11: A valid operation with both masks zero is legal: it changes nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Mode-control operation present |
| op_set | input | 8 | Bits to enable |
| op_clr | input | 8 | Bits to disable |
| wr_en | input | 1 | Direct write strobe |
| wr_data | input | 8 | Direct write value |
| rd_data | output | 8 | Value currently in effect |
| arith_bank_sel | output | 1 | Arithmetic register bank select |
| bitrev_en | output | 1 | Bit-reverse addressing mode |
| ovf_latch_en | output | 1 | ALU overflow latch mode |
| sat_en | output | 1 | Saturation mode |
| mul_place_en | output | 1 | Multiply result placement mode |
| timer_en | output | 1 | Timer enable |
| alt_bank_sel | output | 1 | Secondary address register bank select |
| gie | output | 1 | Global interrupt enable |
| op_illegal | output | 1 | Pulse for a refused mixed operation |

## Verification
The hardest case to reach is an operation that falls inside a write's latency window. It matters most when the operation lands on the same edge as the write, or when two writes in flight must each pick up a different tail of later operations. Directed sequences therefore place operations one and two cycles after a write strobe, and also after back-to-back strobes. A long stretch of mixed traffic then follows, with dense writes and operations. A behavioural queue model predicts every cycle of that traffic, including the refused mixed operations that fall inside a window.

// File: rtl/mode_reg_pkg.sv
package mode_reg_pkg;
  localparam int MODE_W = 8;

  localparam int BIT_ARITH_BANK = 0;
  localparam int BIT_BITREV     = 1;
  localparam int BIT_OVF_LATCH  = 2;
  localparam int BIT_SAT        = 3;
  localparam int BIT_MUL_PLACE  = 4;
  localparam int BIT_TIMER      = 5;
  localparam int BIT_ALT_BANK   = 6;
  localparam int BIT_GIE        = 7;

  typedef struct packed {
    logic [MODE_W-1:0] set;
    logic [MODE_W-1:0] clr;
  } mask_t;

  // Compose an accumulated mask with a later operation; the later one wins per bit.
  function automatic mask_t mask_fold(mask_t acc, mask_t op, logic en);
    mask_t r;
    if (en) begin
      r.set = (acc.set & ~op.clr) | op.set;
      r.clr = (acc.clr & ~op.set) | op.clr;
    end else begin
      r = acc;
    end
    return r;
  endfunction

  function automatic logic [MODE_W-1:0] mask_apply(logic [MODE_W-1:0] v, mask_t m);
    return (v | m.set) & ~m.clr;
  endfunction
endpackage

// File: rtl/mode_op_decode.sv
module mode_op_decode
  import mode_reg_pkg::*;
(
  input  logic              op_valid,
  input  logic [MODE_W-1:0] op_set,
  input  logic [MODE_W-1:0] op_clr,
  output logic              op_ok,
  output logic              op_bad,
  output mask_t             op_m
);
  logic mixed;

  always_comb begin
    mixed    = (|op_set) && (|op_clr);
    op_bad   = op_valid && mixed;
    op_ok    = op_valid && !mixed;
    op_m.set = op_set;
    op_m.clr = op_clr;
  end
endmodule

// File: rtl/mode_wr_pipe.sv
module mode_wr_pipe
  import mode_reg_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  input  logic              op_ok,
  input  mask_t             op_m,
  output logic              land_v,
  output logic [MODE_W-1:0] land_val
);
  localparam int LAST = LAT - 1;
  localparam mask_t NO_MASK = '0;

  logic [LAT-1:0]    stg_v;
  logic [MODE_W-1:0] stg_d [LAT];
  mask_t             stg_m [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg_v[i] <= 1'b0;
        else     stg_v[i] <= wr_en;
        stg_d[i] <= wr_data;
        stg_m[i] <= mask_fold(NO_MASK, op_m, op_ok);
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg_v[i] <= 1'b0;
        else     stg_v[i] <= stg_v[i-1];
        stg_d[i] <= stg_d[i-1];
        stg_m[i] <= mask_fold(stg_m[i-1], op_m, op_ok);
      end
    end
  end

  always_comb begin
    land_v   = stg_v[LAST];
    land_val = mask_apply(stg_d[LAST], mask_fold(stg_m[LAST], op_m, op_ok));
  end
endmodule

// File: rtl/mode_reg_ctl.sv
module mode_reg_ctl
  import mode_reg_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [MODE_W-1:0] op_set,
  input  logic [MODE_W-1:0] op_clr,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output logic [MODE_W-1:0] rd_data,
  output logic              arith_bank_sel,
  output logic              bitrev_en,
  output logic              ovf_latch_en,
  output logic              sat_en,
  output logic              mul_place_en,
  output logic              timer_en,
  output logic              alt_bank_sel,
  output logic              gie,
  output logic              op_illegal
);
  logic              op_ok;
  logic              op_bad;
  mask_t             op_m;
  logic              land_v;
  logic [MODE_W-1:0] land_val;
  logic [MODE_W-1:0] mode_q;
  logic              err_q;

  mode_op_decode u_dec (
    .op_valid (op_valid),
    .op_set   (op_set),
    .op_clr   (op_clr),
    .op_ok    (op_ok),
    .op_bad   (op_bad),
    .op_m     (op_m)
  );

  mode_wr_pipe #(.LAT(LAT)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .op_ok    (op_ok),
    .op_m     (op_m),
    .land_v   (land_v),
    .land_val (land_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (land_v)     mode_q <= land_val;
      else if (op_ok) mode_q <= mask_apply(mode_q, op_m);
      err_q <= op_bad;
    end
  end

  assign rd_data        = mode_q;
  assign arith_bank_sel = mode_q[BIT_ARITH_BANK];
  assign bitrev_en      = mode_q[BIT_BITREV];
  assign ovf_latch_en   = mode_q[BIT_OVF_LATCH];
  assign sat_en         = mode_q[BIT_SAT];
  assign mul_place_en   = mode_q[BIT_MUL_PLACE];
  assign timer_en       = mode_q[BIT_TIMER];
  assign alt_bank_sel   = mode_q[BIT_ALT_BANK];
  assign gie            = mode_q[BIT_GIE];
  assign op_illegal     = err_q;
endmodule

// File: rtl/mode_reg_ctl_chk.sv
module mode_reg_ctl_chk
  import mode_reg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [MODE_W-1:0] op_set,
  input logic [MODE_W-1:0] op_clr,
  input logic [MODE_W-1:0] rd_data,
  input logic              alt_bank_sel,
  input logic              gie,
  input logic              op_illegal,
  input logic              land_v
);
  // R5
  mixed_op_refused_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (|op_set) && (|op_clr) && !land_v) |=> ($stable(rd_data) && op_illegal));

  // R5
  err_only_after_mixed_chk: assert property (@(posedge clk) disable iff (rst)
    (!(op_valid && (|op_set) && (|op_clr))) |=> !op_illegal);

  // R2
  set_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_clr == '0) && !land_v) |=> ((rd_data & $past(op_set)) == $past(op_set)));

  // R3
  clr_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_set == '0) && !land_v) |=> ((rd_data & $past(op_clr)) == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !land_v) |=> $stable(rd_data));

  // R9
  always @(negedge clk) begin
    if (!rst) begin
      bank_gie_map_chk: assert (alt_bank_sel == rd_data[BIT_ALT_BANK] && gie == rd_data[BIT_GIE]);
    end
  end
endmodule

bind mode_reg_ctl mode_reg_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .op_set       (op_set),
  .op_clr       (op_clr),
  .rd_data      (rd_data),
  .alt_bank_sel (alt_bank_sel),
  .gie          (gie),
  .op_illegal   (op_illegal),
  .land_v       (land_v)
);

// File: tb/mode_reg_ctl_test.sv
`timescale 1ns/1ps
module mode_reg_ctl_test;
  localparam int LAT = 2;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [7:0] op_set, op_clr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic arith_bank_sel, bitrev_en, ovf_latch_en, sat_en, mul_place_en, timer_en;
  logic alt_bank_sel, gie, op_illegal;

  int checks = 0;
  int errors = 0;

  int exp_val = 0;
  int exp_ill = 0;
  int q_d[$], q_s[$], q_c[$], q_a[$];
  string tag = "R1";

  always #2.5 clk = ~clk;

  mode_reg_ctl #(.LAT(LAT)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_set(op_set), .op_clr(op_clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .arith_bank_sel(arith_bank_sel), .bitrev_en(bitrev_en), .ovf_latch_en(ovf_latch_en),
    .sat_en(sat_en), .mul_place_en(mul_place_en), .timer_en(timer_en),
    .alt_bank_sel(alt_bank_sel), .gie(gie), .op_illegal(op_illegal)
  );

  // Reference model: one update per rising edge, from the inputs the bench drove.
  task automatic model_edge();
    int s, c, ns, nc;
    bit legal;
    bit landed;
    if (rst) begin
      exp_val = 0; exp_ill = 0;
      q_d.delete(); q_s.delete(); q_c.delete(); q_a.delete();
      return;
    end
    s = op_set; c = op_clr;
    legal  = op_valid && !(s != 0 && c != 0);
    exp_ill = (op_valid && s != 0 && c != 0) ? 1 : 0;
    landed = 0;
    if (q_a.size() > 0 && q_a[0] == LAT) begin
      ns = q_s[0]; nc = q_c[0];
      if (legal) begin ns = (ns & ~c) | s; nc = (nc & ~s) | c; end
      exp_val = (q_d[0] | ns) & ~nc & 8'hFF;
      landed = 1;
      void'(q_d.pop_front()); void'(q_s.pop_front());
      void'(q_c.pop_front()); void'(q_a.pop_front());
    end
    foreach (q_a[i]) begin
      if (legal) begin
        ns = (q_s[i] & ~c) | s; nc = (q_c[i] & ~s) | c;
        q_s[i] = ns; q_c[i] = nc;
      end
      q_a[i] = q_a[i] + 1;
    end
    if (wr_en) begin
      q_d.push_back(wr_data);
      q_s.push_back(legal ? s : 0);
      q_c.push_back(legal ? c : 0);
      q_a.push_back(1);
    end
    if (!landed && legal) exp_val = (exp_val | s) & ~c & 8'hFF;
  endtask

  task automatic compare();
    logic [7:0] outs;
    outs = {gie, alt_bank_sel, timer_en, mul_place_en, sat_en, ovf_latch_en, bitrev_en, arith_bank_sel};
    checks++;
    if (rd_data !== exp_val[7:0] || outs !== exp_val[7:0] || op_illegal !== exp_ill[0]) begin
      errors++;
      $display("FAIL %s: rd_data=%h bits=%h op_illegal=%b expected rd_data=%h bits=%h op_illegal=%0d",
               tag, rd_data, outs, op_illegal, exp_val[7:0], exp_val[7:0], exp_ill);
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] s, input logic [7:0] c,
                     input bit we, input logic [7:0] wd, input string t);
    tag = t;
    op_valid = v; op_set = s; op_clr = c; wr_en = we; wr_data = wd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 8'h00, 0, 8'h00, t);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; op_valid = 0; op_set = 0; op_clr = 0; wr_en = 0; wr_data = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); model_edge();
    end
    @(negedge clk);
    rst = 1'b0;
    tag = "R1"; compare();

    // R2 single set, zero latency; R9 bit mapping via each output
    cyc(1, 8'h40, 8'h00, 0, 8'h00, "R2");
    cyc(1, 8'h80, 8'h00, 0, 8'h00, "R9");
    // R4 several at once
    cyc(1, 8'h3F, 8'h00, 0, 8'h00, "R4");
    // R3 clear, R4 clear several
    cyc(1, 8'h00, 8'h05, 0, 8'h00, "R3");
    cyc(1, 8'h00, 8'hC0, 0, 8'h00, "R4");
    // R5 mixed op refused, pulse one cycle
    cyc(1, 8'h40, 8'h01, 0, 8'h00, "R5");
    idle(1, "R5");
    cyc(1, 8'hFF, 8'hFF, 0, 8'h00, "R5");
    cyc(1, 8'h80, 8'h02, 0, 8'h00, "R5");
    idle(2, "R5");
    // R10 masks ignored when not valid
    cyc(0, 8'hC0, 8'h00, 0, 8'h00, "R10");
    cyc(0, 8'h00, 8'hFF, 0, 8'h00, "R10");
    // R11 empty op
    cyc(1, 8'h00, 8'h00, 0, 8'h00, "R11");
    // R6 direct write latency
    cyc(0, 8'h00, 8'h00, 1, 8'hA5, "R6");
    idle(3, "R6");
    // R7 op one cycle after strobe, then on landing edge
    cyc(0, 8'h00, 8'h00, 1, 8'h0F, "R7");
    cyc(1, 8'h80, 8'h00, 0, 8'h00, "R7");
    cyc(1, 8'h00, 8'h01, 0, 8'h00, "R7");
    idle(2, "R7");
    // R7 op on issue edge, and a refused op inside the window
    cyc(1, 8'h40, 8'h00, 1, 8'h00, "R7");
    cyc(1, 8'h02, 8'h04, 0, 8'h00, "R7");
    idle(2, "R7");
    // R8 back-to-back writes with ops between
    cyc(0, 8'h00, 8'h00, 1, 8'h11, "R8");
    cyc(1, 8'h20, 8'h00, 1, 8'h22, "R8");
    cyc(1, 8'h00, 8'h02, 1, 8'h44, "R8");
    cyc(0, 8'h00, 8'h00, 0, 8'h00, "R8");
    idle(3, "R8");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, b;
      int k;
      k = $urandom_range(0, 9);
      a = 8'($urandom); b = 8'($urandom);
      case (k)
        0, 1: cyc(1, a, 8'h00, (k == 1), b, "R7");
        2, 3: cyc(1, 8'h00, a, (k == 3), b, "R7");
        4:    cyc(1, a | 8'h01, b | 8'h01, 0, b, "R5");
        5:    cyc(0, a, b, 1, b, "R8");
        6:    cyc(1, 8'h00, 8'h00, 0, b, "R11");
        default: cyc(0, a, b, 0, b, "R10");
      endcase
    end
    idle(4, "R6");

    rst = 1'b1;
    @(posedge clk); model_edge();
    @(negedge clk);
    rst = 1'b0;
    tag = "R1"; compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule